// File: doc/BRIEF.md
# Programmable Frequency Generator Bank

This block holds six programmable rate generators that are all set up through two 32-bit configuration words. Each word holds three generators. Every generator picks one of several input rate strobes, counts that strobe down by a programmed divisor and emits a one-cycle tick when the count completes. A generator can also be switched off. The input "clocks" are modelled as single-cycle enable strobes, so the whole bank runs on one fast clock. Each output is likewise a tick stream, which downstream logic uses as a clock enable.

A build parameter selects one of two slot layouts. The older layout has a two-way source bit, a separate enable bit and even divisors only. The newer layout has a three-way source field in which code zero means "off". It also has one scale bit per configuration word, and that bit lets the divisors of the word's three generators take every integer value. Software can overwrite a whole word, or it can update only the 8-bit divider field of a single generator. Both kinds of write may be issued in the same cycle.

Top module: `fgen_bank`

## Requirements
- R1: While reset is asserted, and right after it, both configuration words read 0 and no generator ticks, in either layout.
- R2: A full write of word W stores the 32-bit value, and a read of W returns exactly that value. The other word is not disturbed.
- R3: A divider-field write to generator G replaces only bits 10·(G mod 3)+9 down to 10·(G mod 3)+2 of word G div 3. Generators 0–2 live in word 0 and generators 3–5 in word 1. Every other bit of both words is kept.
- R4: When a full write and a divider-field write land in the same cycle, the full write is applied first and the field write then overrides its own 8 bits. If the two writes address different words, both take effect.
- R5: Older layout: slot bit 1 = 1 enables the generator, and slot bit 0 picks input 0 (value 0) or input 1 (value 1). The divisor is (N+1)×2, where N is slot bits 9:2, so the range is 2..512.
- R6: Newer layout: slot bits 1:0 = 0 disables the generator, and codes 1, 2 and 3 select inputs 0, 1 and 2. No separate enable bit exists.
- R7: Newer layout: bit 30 of a word is shared by the word's three generators. When it is set, the divisor is N+1 (1..256). When it is clear, the divisor is (N+1)×2. The older layout ignores bit 30.
- R8: An enabled generator counts only strobes of its selected input. Its tick is one clock wide and appears in the cycle after the strobe that completes each group of divisor strobes. This includes a divisor of 1, where every strobe ticks, and a divisor of 512.
- R9: A disabled generator never ticks, and its count is held at zero. After it is re-enabled, the first tick needs a full divisor of strobes.
- R10: When a generator's decoded setup (enable, source or divisor) changes, its count clears and a strobe in that cycle is not counted. Rewriting an identical value does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock shared by the whole bank |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Full-word write strobe |
| reg_wr_sel | input | 1 | Word selected by the full write |
| reg_wr_data | input | 32 | Data for the full write |
| div_wr_en | input | 1 | Divider-field write strobe |
| div_wr_gen | input | 3 | Generator addressed by the field write (0..5) |
| div_wr_val | input | 8 | New divider value N |
| reg_rd_sel | input | 1 | Word placed on the read bus |
| reg_rd_data | output | 32 | Contents of the selected word |
| src_stb | input | 3 | Input rate strobes, one per source |
| gen_tick | output | 6 | One tick stream per generator |

## Verification
A full-word write and a divider-field write can arrive in the same cycle. The bench issues both together on the same word, where the field must win its 8 bits, and then on different words, where both must stick. It judges the outcome by reading back the words. The other collision is a setup change in the same cycle as a strobe of the selected input. The bench places a strobe in the exact cycle that follows a divider update, and it requires the next tick to come only after a full new divisor of strobes.

// File: rtl/fgen_pkg.sv
package fgen_pkg;

  localparam int FG_SLOT_W    = 10;
  localparam int FG_DIV_W     = 8;
  localparam int FG_DIV_LSB   = 2;
  localparam int FG_SCALE_BIT = 30;
  localparam int FG_SRC_N     = 3;
  localparam int FG_SRC_W     = 2;
  localparam int FG_CNT_W     = FG_DIV_W + 2;

  typedef struct packed {
    logic                active;
    logic [FG_SRC_W-1:0] src;
    logic [FG_CNT_W-1:0] divisor;
  } fg_cfg_t;

  // Divisor from the stored field: N+1 in unit steps, else twice that.
  function automatic logic [FG_CNT_W-1:0] fg_divisor(input logic [FG_DIV_W-1:0] n,
                                                     input logic unit_step);
    logic [FG_CNT_W-1:0] base;
    base = FG_CNT_W'(n) + FG_CNT_W'(1);
    return unit_step ? base : (base << 1);
  endfunction

  // Turn a raw slot into enable, source index and divisor.
  function automatic fg_cfg_t fg_decode(input logic [FG_SLOT_W-1:0] slot,
                                        input logic scale,
                                        input logic ext);
    fg_cfg_t             c;
    logic [FG_DIV_W-1:0] n;
    n = slot[FG_DIV_LSB +: FG_DIV_W];
    if (ext) begin
      c.active  = (slot[1:0] != 2'd0);
      c.src     = FG_SRC_W'(slot[1:0] - 2'd1);
      c.divisor = fg_divisor(n, scale);
    end else begin
      c.active  = slot[1];
      c.src     = FG_SRC_W'(slot[0]);
      c.divisor = fg_divisor(n, 1'b0);
    end
    return c;
  endfunction

endpackage

// File: rtl/fgen_regs.sv
module fgen_regs #(
  parameter int NUM_REGS    = 2,
  parameter int REG_W       = 32,
  parameter int NUM_GEN     = 6,
  parameter int GEN_PER_REG = 3,
  parameter int SLOT_W      = 10,
  parameter int DIV_LSB     = 2,
  parameter int DIV_W       = 8,
  parameter int SEL_W       = 1,
  parameter int GEN_IDX_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr_en,
  input  logic [SEL_W-1:0]          reg_wr_sel,
  input  logic [REG_W-1:0]          reg_wr_data,
  input  logic                      div_wr_en,
  input  logic [GEN_IDX_W-1:0]      div_wr_gen,
  input  logic [DIV_W-1:0]          div_wr_val,
  input  logic [SEL_W-1:0]          reg_rd_sel,
  output logic [REG_W-1:0]          reg_rd_data,
  output logic [NUM_REGS*REG_W-1:0] cfg_flat
);

  localparam int FLAT_W = NUM_REGS * REG_W;

  logic [FLAT_W-1:0] words_q;
  logic [FLAT_W-1:0] words_d;

  // Full write first, divider-field write overlays it afterwards.
  always_comb begin
    words_d = words_q;
    if (reg_wr_en && (int'(reg_wr_sel) < NUM_REGS)) begin
      words_d[int'(reg_wr_sel)*REG_W +: REG_W] = reg_wr_data;
    end
    for (int g = 0; g < NUM_GEN; g++) begin
      if (div_wr_en && (div_wr_gen == GEN_IDX_W'(g))) begin
        words_d[(g / GEN_PER_REG)*REG_W + (g % GEN_PER_REG)*SLOT_W + DIV_LSB +: DIV_W] = div_wr_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_q <= '0;
    end else begin
      words_q <= words_d;
    end
  end

  always_comb begin
    reg_rd_data = '0;
    if (int'(reg_rd_sel) < NUM_REGS) begin
      reg_rd_data = words_q[int'(reg_rd_sel)*REG_W +: REG_W];
    end
  end

  assign cfg_flat = words_q;

endmodule

// File: rtl/fgen_divider.sv
module fgen_divider
  import fgen_pkg::*;
#(
  parameter int SRC_N = FG_SRC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fg_cfg_t          cfg_i,
  input  logic [SRC_N-1:0] src_stb,
  output logic             tick_o,
  output logic             restart_o,
  output logic             term_o
);

  fg_cfg_t             cfg_q;
  logic [FG_CNT_W-1:0] cnt_q;
  logic                sel_stb;
  logic                changed;
  logic                stb_hit;
  logic                term;

  always_comb begin
    sel_stb = 1'b0;
    for (int i = 0; i < SRC_N; i++) begin
      if (cfg_i.src == FG_SRC_W'(i)) sel_stb = src_stb[i];
    end
  end

  assign changed = (cfg_i != cfg_q);
  assign stb_hit = cfg_i.active && sel_stb && !changed;
  assign term    = stb_hit && (cnt_q == (cfg_i.divisor - FG_CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      cfg_q  <= cfg_i;
      tick_o <= term;
      if (!cfg_i.active || changed) begin
        cnt_q <= '0;
      end else if (stb_hit) begin
        cnt_q <= term ? '0 : cnt_q + FG_CNT_W'(1);
      end
    end
  end

  assign restart_o = changed;
  assign term_o    = term;

endmodule

// File: rtl/fgen_bank.sv
module fgen_bank
  import fgen_pkg::*;
#(
  parameter bit EXTENDED    = 1'b1,
  parameter int NUM_GEN     = 6,
  parameter int GEN_PER_REG = 3,
  parameter int REG_W       = 32,
  parameter int DIV_W       = FG_DIV_W,
  parameter int SRC_N       = FG_SRC_N,
  parameter int NUM_REGS    = (NUM_GEN + GEN_PER_REG - 1) / GEN_PER_REG,
  parameter int SEL_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  parameter int GEN_IDX_W   = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [SEL_W-1:0]     reg_wr_sel,
  input  logic [REG_W-1:0]     reg_wr_data,
  input  logic                 div_wr_en,
  input  logic [GEN_IDX_W-1:0] div_wr_gen,
  input  logic [DIV_W-1:0]     div_wr_val,
  input  logic [SEL_W-1:0]     reg_rd_sel,
  output logic [REG_W-1:0]     reg_rd_data,
  input  logic [SRC_N-1:0]     src_stb,
  output logic [NUM_GEN-1:0]   gen_tick
);

  logic [NUM_REGS*REG_W-1:0] cfg_flat;
  logic [NUM_GEN-1:0]        gen_active;
  logic [NUM_GEN-1:0]        gen_restart;
  logic [NUM_GEN-1:0]        gen_term;

  fgen_regs #(
    .NUM_REGS    (NUM_REGS),
    .REG_W       (REG_W),
    .NUM_GEN     (NUM_GEN),
    .GEN_PER_REG (GEN_PER_REG),
    .SLOT_W      (FG_SLOT_W),
    .DIV_LSB     (FG_DIV_LSB),
    .DIV_W       (DIV_W),
    .SEL_W       (SEL_W),
    .GEN_IDX_W   (GEN_IDX_W)
  ) i_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_sel  (reg_wr_sel),
    .reg_wr_data (reg_wr_data),
    .div_wr_en   (div_wr_en),
    .div_wr_gen  (div_wr_gen),
    .div_wr_val  (div_wr_val),
    .reg_rd_sel  (reg_rd_sel),
    .reg_rd_data (reg_rd_data),
    .cfg_flat    (cfg_flat)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    localparam int WORD_BASE = (g / GEN_PER_REG) * REG_W;
    localparam int SLOT_BASE = WORD_BASE + (g % GEN_PER_REG) * FG_SLOT_W;

    fg_cfg_t cfg;
    assign cfg           = fg_decode(cfg_flat[SLOT_BASE +: FG_SLOT_W],
                                     cfg_flat[WORD_BASE + FG_SCALE_BIT], EXTENDED);
    assign gen_active[g] = cfg.active;

    fgen_divider #(
      .SRC_N (SRC_N)
    ) i_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_i     (cfg),
      .src_stb   (src_stb),
      .tick_o    (gen_tick[g]),
      .restart_o (gen_restart[g]),
      .term_o    (gen_term[g])
    );
  end

endmodule

// File: rtl/fgen_bank_chk.sv
module fgen_bank_chk #(
  parameter int NUM_GEN = 6,
  parameter int FLAT_W  = 64,
  parameter int SRC_N   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr_en,
  input logic               div_wr_en,
  input logic [FLAT_W-1:0]  cfg_flat,
  input logic [SRC_N-1:0]   src_stb,
  input logic [NUM_GEN-1:0] gen_active,
  input logic [NUM_GEN-1:0] gen_restart,
  input logic [NUM_GEN-1:0] gen_tick
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (cfg_flat == '0) && (gen_tick == '0));

  // R2
  words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_en && !div_wr_en) |=> $stable(cfg_flat));

  // R8
  tick_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|gen_tick) |-> $past(|src_stb));

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
    // R9
    disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_active[g] |=> !gen_tick[g]);

    // R10
    restart_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gen_restart[g] |=> !gen_tick[g]);
  end

endmodule

bind fgen_bank fgen_bank_chk #(
  .NUM_GEN (NUM_GEN),
  .FLAT_W  (NUM_REGS*REG_W),
  .SRC_N   (SRC_N)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .div_wr_en   (div_wr_en),
  .cfg_flat    (cfg_flat),
  .src_stb     (src_stb),
  .gen_active  (gen_active),
  .gen_restart (gen_restart),
  .gen_tick    (gen_tick)
);

// File: tb/test_fgen_bank.sv
module test_fgen_bank;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_wr_sel = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic        div_wr_en = 1'b0;
  logic [2:0]  div_wr_gen = '0;
  logic [7:0]  div_wr_val = '0;
  logic        reg_rd_sel = 1'b0;
  logic [2:0]  src_stb = '0;
  logic [31:0] rd_ext, rd_leg;
  logic [5:0]  tick_ext, tick_leg;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fgen_bank #(.EXTENDED(1'b1)) i_fgen_bank (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .div_wr_en(div_wr_en), .div_wr_gen(div_wr_gen),
    .div_wr_val(div_wr_val), .reg_rd_sel(reg_rd_sel), .reg_rd_data(rd_ext),
    .src_stb(src_stb), .gen_tick(tick_ext));

  fgen_bank #(.EXTENDED(1'b0)) i_fgen_bank_legacy (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .div_wr_en(div_wr_en), .div_wr_gen(div_wr_gen),
    .div_wr_val(div_wr_val), .reg_rd_sel(reg_rd_sel), .reg_rd_data(rd_leg),
    .src_stb(src_stb), .gen_tick(tick_leg));

  task automatic report(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Writes are driven at a falling edge and end at the next falling edge.
  task automatic write_both(input logic wr, input logic sel, input logic [31:0] data,
                            input logic fw, input logic [2:0] gen, input logic [7:0] val);
    reg_wr_en = wr; reg_wr_sel = sel; reg_wr_data = data;
    div_wr_en = fw; div_wr_gen = gen; div_wr_val = val;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0; div_wr_en = 1'b0;
  endtask

  task automatic write_reg(input logic sel, input logic [31:0] data);
    write_both(1'b1, sel, data, 1'b0, 3'd0, 8'd0);
  endtask

  task automatic write_field(input logic [2:0] gen, input logic [7:0] val);
    write_both(1'b0, 1'b0, 32'd0, 1'b1, gen, val);
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_rd(input logic sel, input logic [31:0] exp, input string tag);
    reg_rd_sel = sel;
    #1;
    report({tag, " ext read"}, rd_ext, exp);
    report({tag, " legacy read"}, rd_leg, exp);
  endtask

  // One strobe cycle; ticks are registered, so sample just after the edge.
  task automatic step(input logic [2:0] stb, input logic [5:0] exp_leg,
                      input logic [5:0] exp_ext, input string tag);
    src_stb = stb;
    @(posedge clk);
    #1;
    report({tag, " legacy ticks"}, 32'(tick_leg), 32'(exp_leg));
    report({tag, " ext ticks"}, 32'(tick_ext), 32'(exp_ext));
    @(negedge clk);
    src_stb = '0;
  endtask

  task automatic t_reset();
    check_rd(1'b0, 32'd0, "R1 word0");
    check_rd(1'b1, 32'd0, "R1 word1");
    step(3'b111, 6'd0, 6'd0, "R1 quiet");
  endtask

  task automatic t_regrw();
    write_reg(1'b0, 32'hA5A5_1234);
    check_rd(1'b0, 32'hA5A5_1234, "R2 word0");
    check_rd(1'b1, 32'd0, "R2 word1 untouched");
    write_reg(1'b0, 32'd0);
    idle();
  endtask

  task automatic t_legacy();
    write_reg(1'b0, 32'd11);  // N=2, enabled, input 1
    idle();
    for (int k = 1; k <= 6; k++) step(3'b001, 6'd0, 6'd0, "R5 other input ignored");
    for (int k = 1; k <= 6; k++)
      step(3'b010, (k == 6) ? 6'd1 : 6'd0, 6'd0, "R5 divide by 6");
  endtask

  task automatic t_scale();
    write_reg(1'b0, 32'h4000_000B);
    idle();
    for (int k = 1; k <= 6; k++)
      step(3'b010, (k == 6) ? 6'd1 : 6'd0, 6'd0, "R7 legacy ignores scale");
    for (int k = 1; k <= 3; k++)
      step(3'b100, 6'd0, (k == 3) ? 6'd1 : 6'd0, "R7 scale set divide by 3");
    write_reg(1'b0, 32'd11);
    idle();
    for (int k = 1; k <= 6; k++)
      step(3'b100, 6'd0, (k == 6) ? 6'd1 : 6'd0, "R7 scale clear divide by 6");
    write_reg(1'b0, 32'd0);
    idle();
  endtask

  task automatic t_codes();
    write_reg(1'b1, 32'h4000_1400);  // gen4 code 1 N=1 scale; gen3 code 0
    idle();
    for (int k = 1; k <= 2; k++)
      step(3'b001, 6'd0, (k == 2) ? 6'h10 : 6'd0, "R6 code1 input0 divide 2");
    for (int k = 1; k <= 2; k++) step(3'b010, 6'd0, 6'd0, "R6 code1 ignores input1");
    write_reg(1'b1, 32'h4000_0002);  // gen3 code 2 N=0 scale
    idle();
    step(3'b010, 6'd0, 6'h08, "R8 divisor one tick");
    step(3'b010, 6'd0, 6'h08, "R8 divisor one again");
    step(3'b001, 6'd0, 6'd0, "R5 legacy gen3 first");
    step(3'b001, 6'h08, 6'd0, "R5 legacy gen3 second");
    write_reg(1'b1, 32'd0);
    idle();
  endtask

  task automatic t_field();
    write_reg(1'b0, 32'hFFFF_FFFF);
    write_field(3'd1, 8'h7F);
    check_rd(1'b0, 32'hFFF7_FFFF, "R3 gen1 field");
    write_field(3'd4, 8'hFF);
    check_rd(1'b1, 32'h000F_F000, "R3 gen4 field");
  endtask

  task automatic t_both();
    write_both(1'b1, 1'b0, 32'h1234_5678, 1'b1, 3'd2, 8'h00);
    check_rd(1'b0, 32'h0034_5678, "R4 same word");
    write_both(1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1, 3'd0, 8'h00);
    check_rd(1'b0, 32'h0034_5400, "R4 cross word field");
    check_rd(1'b1, 32'hFFFF_FFFF, "R4 cross word full");
    write_reg(1'b0, 32'd0);
    write_reg(1'b1, 32'd0);
    idle();
  endtask

  task automatic t_maxdiv();
    write_reg(1'b0, 32'h0000_03FE);  // N=255 enabled input 0
    idle();
    for (int k = 1; k <= 513; k++)
      step(3'b001, (k == 512) ? 6'd1 : 6'd0, 6'd0, "R8 divide by 512");
    write_reg(1'b0, 32'd0);
    idle();
  endtask

  task automatic t_disable();
    write_reg(1'b0, 32'd6);  // N=1 enabled input 0
    idle();
    for (int k = 1; k <= 2; k++) step(3'b001, 6'd0, 6'd0, "R9 partial count");
    write_reg(1'b0, 32'd4);
    idle();
    for (int k = 1; k <= 5; k++) step(3'b001, 6'd0, 6'd0, "R9 disabled input0");
    for (int k = 1; k <= 5; k++) step(3'b010, 6'd0, 6'd0, "R9 disabled input1");
    write_reg(1'b0, 32'd6);
    idle();
    for (int k = 1; k <= 4; k++)
      step(3'b001, (k == 4) ? 6'd1 : 6'd0, 6'd0, "R9 full period after enable");
  endtask

  task automatic t_restart();
    for (int k = 1; k <= 3; k++) step(3'b001, 6'd0, 6'd0, "R10 pre count");
    write_field(3'd0, 8'h01);
    step(3'b001, 6'd1, 6'd0, "R10 same value keeps count");
    for (int k = 1; k <= 3; k++) step(3'b001, 6'd0, 6'd0, "R10 pre count again");
    write_field(3'd0, 8'h02);
    step(3'b001, 6'd0, 6'd0, "R10 strobe in change cycle");
    for (int k = 1; k <= 6; k++)
      step(3'b001, (k == 6) ? 6'd1 : 6'd0, 6'd0, "R10 fresh period of 6");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regrw();
    t_legacy();
    t_scale();
    t_codes();
    t_field();
    t_both();
    t_maxdiv();
    t_disable();
    t_restart();
    finish_run();
  end

endmodule